// File: doc/BRIEF.md
# Reactive Safe-Wander Motion Controller

This block is the lowest behaviour layer of a small differential-drive robot. It watches a set of pre-evaluated proximity flags (another robot on the left or right, an obstacle on the left or right, and a single qualifier saying that whatever is seen lies inside the avoidance distance). From these flags it produces one movement command at a time: forward, turn left, turn right, back up or stop. A busy flag is high while a manoeuvre is running. The controller makes its decisions only on a tick strobe, so the time base comes from outside and can be matched to the speed of the drive.

Robots and fixed obstacles are avoided under different rules, and robot avoidance wins when both apply. Free space gives a forward step followed by a turn in a random direction. The controller keeps a short history of its turns. A third turn in the same direction ends in a back-up and a turn the other way. If both sides are blocked, the robot stops and waits. If the blockage lasts, it backs up and turns in a random direction. A 16-bit LFSR inside the block supplies the random bit.

The states are IDLE (deciding, command stop), FWD (forward step), TURN (reactive or random turn), BACK (reverse), ESC (escape turn after a reverse) and WAIT (stopped on a two-sided blockage). The transitions are:

- IDLE to TURN on a robot or one-sided obstacle.
- IDLE to WAIT on a two-sided blockage.
- IDLE to FWD on free space.
- FWD to TURN when the step ends.
- TURN to IDLE, or TURN to BACK when the run of same-direction turns is full.
- BACK to ESC.
- ESC to IDLE.
- WAIT to IDLE when the blockage clears.
- WAIT to BACK when the wait expires.

Top module: `wander_ctrl`

## Requirements
- R1: After reset the command is stop and busy is low. The command is one-hot: bit 0 forward, bit 1 turn left, bit 2 turn right, bit 3 back up, bit 4 stop. Exactly one bit is set at all times.
- R2: State and command change only on a clock edge where tick is high. Without a tick the command holds, whatever the input flags do.
- R3: In IDLE with near high and a robot flagged, the controller turns right when peer_l is high. When only peer_r is high, it turns left.
- R4: In IDLE with near high, no robot flagged and an obstacle on one side only, the controller turns away from it: obstacle right gives turn left, obstacle left gives turn right.
- R5: When the robot rule and the obstacle rule both apply on the same tick, the robot rule sets the turn.
- R6: With near low, or near high and no flag set, the controller goes forward for FWD_TICKS ticks and then turns in a random direction.
- R7: Every turn lasts TURN_TICKS ticks. After it the controller is back in IDLE (stop, busy low), unless R8 applies.
- R8: When a turn ends and it is the STREAK_MAX-th consecutive turn in the same direction (default 3), the controller backs up for BACK_TICKS ticks. It then turns the opposite way for TURN_TICKS ticks and returns to IDLE.
- R9: The count of same-direction turns restarts at one when the direction changes. It is cleared when a forward step starts.
- R10: In IDLE with near, obst_l and obst_r all high and no robot flagged, the command becomes stop with busy high. A tick on which that condition is gone returns the controller to IDLE.
- R11: If the two-sided blockage is still present on the WAIT_TICKS-th tick in WAIT, the controller backs up for BACK_TICKS ticks. It then turns in a random direction for TURN_TICKS ticks.
- R12: Random directions come from a 16-bit LFSR that is loaded with LFSR_SEED at reset and steps every clock. Every random choice is a turn, left or right.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Decision strobe; all state moves happen on it |
| near | input | 1 | Flagged robot or obstacle lies within avoid distance |
| peer_l | input | 1 | Nearest robot is on the left |
| peer_r | input | 1 | A robot is on the right |
| obst_l | input | 1 | Obstacle on the left |
| obst_r | input | 1 | Obstacle on the right |
| cmd | output | 5 | One-hot movement command |
| busy | output | 1 | High while a manoeuvre or wait is in progress |

## Verification
The bench builds the controller with FWD_TICKS=3, TURN_TICKS=2, BACK_TICKS=2 and WAIT_TICKS=5. With these values every phase boundary can be reached in a few ticks, including the last tick of a wait before the escape. STREAK_MAX stays at 3, so three-turn runs, broken runs and runs cleared by a forward step can all be driven in short sequences. Random turns are checked for being a legal turn rather than for a fixed direction.

// File: rtl/wander_pkg.sv
package wander_pkg;

    typedef enum logic [4:0] {
        MV_FWD   = 5'b00001,
        MV_LEFT  = 5'b00010,
        MV_RIGHT = 5'b00100,
        MV_BACK  = 5'b01000,
        MV_STOP  = 5'b10000
    } move_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FWD,
        ST_TURN,
        ST_BACK,
        ST_ESC,
        ST_WAIT
    } wstate_t;

    localparam logic DIR_L = 1'b0;
    localparam logic DIR_R = 1'b1;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wander_lfsr.sv
module wander_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic clk,
    input  logic rst_n,
    output logic rnd
);
    logic [15:0] sr_q;
    logic        fb;

    assign fb  = sr_q[15] ^ sr_q[13] ^ sr_q[12] ^ sr_q[10];
    assign rnd = sr_q[15];

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= (SEED == 16'h0) ? 16'h0001 : SEED;
        else        sr_q <= {sr_q[14:0], fb};
    end
endmodule

// File: rtl/wander_phase_timer.sv
module wander_phase_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          clear,
    input  logic [CW-1:0] limit,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    assign last = (cnt_q == (limit - CW'(1)));

    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (clear)       cnt_q <= '0;
        else if (step && !last) cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/wander_turn_history.sv
module wander_turn_history #(
    parameter int STREAK_MAX = 3,
    localparam int SW = $clog2(STREAK_MAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic push,
    input  logic push_dir,
    output logic full
);
    logic [SW-1:0] run_q;
    logic          last_dir_q;

    assign full = (run_q >= SW'(STREAK_MAX));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q      <= '0;
            last_dir_q <= 1'b0;
        end else if (clear) begin
            run_q <= '0;
        end else if (push) begin
            last_dir_q <= push_dir;
            if (run_q != '0 && push_dir == last_dir_q) begin
                if (!full) run_q <= run_q + SW'(1);
            end else begin
                run_q <= SW'(1);
            end
        end
    end
endmodule

// File: rtl/wander_ctrl.sv
module wander_ctrl
    import wander_pkg::*;
#(
    parameter int          FWD_TICKS  = 8,
    parameter int          TURN_TICKS = 4,
    parameter int          BACK_TICKS = 4,
    parameter int          WAIT_TICKS = 16,
    parameter int          STREAK_MAX = 3,
    parameter logic [15:0] LFSR_SEED  = 16'hACE1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       near,
    input  logic       peer_l,
    input  logic       peer_r,
    input  logic       obst_l,
    input  logic       obst_r,
    output logic [4:0] cmd,
    output logic       busy
);
    localparam int MAXT = imax(imax(FWD_TICKS, TURN_TICKS), imax(BACK_TICKS, WAIT_TICKS));
    localparam int CW   = $clog2(MAXT + 1);

    wstate_t       state_q, state_d;
    logic          dir_q, dir_d;
    logic          rnd;
    logic          ph_last, ph_clear;
    logic [CW-1:0] ph_limit;
    logic          hist_full, hist_push, hist_clr;
    logic          blocked, peer_near;

    assign blocked   = near & obst_l & obst_r;
    assign peer_near = near & (peer_l | peer_r);

    wander_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
        .clk  (clk),
        .rst_n(rst_n),
        .rnd  (rnd)
    );

    always_comb begin
        unique case (state_q)
            ST_FWD:         ph_limit = CW'(FWD_TICKS);
            ST_TURN,ST_ESC: ph_limit = CW'(TURN_TICKS);
            ST_BACK:        ph_limit = CW'(BACK_TICKS);
            ST_WAIT:        ph_limit = CW'(WAIT_TICKS);
            default:        ph_limit = CW'(1);
        endcase
    end

    assign ph_clear = tick && (state_d != state_q);

    wander_phase_timer #(.CW(CW)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .step (tick),
        .clear(ph_clear),
        .limit(ph_limit),
        .last (ph_last)
    );

    wander_turn_history #(.STREAK_MAX(STREAK_MAX)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (hist_clr),
        .push    (hist_push),
        .push_dir(dir_d),
        .full    (hist_full)
    );

    // next-state decision, evaluated only on a tick
    always_comb begin
        state_d   = state_q;
        dir_d     = dir_q;
        hist_push = 1'b0;
        hist_clr  = 1'b0;
        if (tick) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (peer_near) begin
                        state_d   = ST_TURN;
                        dir_d     = peer_l ? DIR_R : DIR_L;
                        hist_push = 1'b1;
                    end else if (blocked) begin
                        state_d = ST_WAIT;
                    end else if (near && obst_r) begin
                        state_d   = ST_TURN;
                        dir_d     = DIR_L;
                        hist_push = 1'b1;
                    end else if (near && obst_l) begin
                        state_d   = ST_TURN;
                        dir_d     = DIR_R;
                        hist_push = 1'b1;
                    end else begin
                        state_d  = ST_FWD;
                        hist_clr = 1'b1;
                    end
                end
                ST_FWD: begin
                    if (ph_last) begin
                        state_d   = ST_TURN;
                        dir_d     = rnd;
                        hist_push = 1'b1;
                    end
                end
                ST_TURN: begin
                    if (ph_last) begin
                        if (hist_full) begin
                            state_d  = ST_BACK;
                            dir_d    = ~dir_q;
                            hist_clr = 1'b1;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                ST_BACK: begin
                    if (ph_last) state_d = ST_ESC;
                end
                ST_ESC: begin
                    if (ph_last) state_d = ST_IDLE;
                end
                ST_WAIT: begin
                    if (!blocked) begin
                        state_d = ST_IDLE;
                    end else if (ph_last) begin
                        state_d = ST_BACK;
                        dir_d   = rnd;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dir_q   <= DIR_L;
        end else begin
            state_q <= state_d;
            dir_q   <= dir_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_FWD:         cmd = MV_FWD;
            ST_TURN,ST_ESC: cmd = (dir_q == DIR_R) ? MV_RIGHT : MV_LEFT;
            ST_BACK:        cmd = MV_BACK;
            default:        cmd = MV_STOP;
        endcase
        busy = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/wander_ctrl_chk.sv
module wander_ctrl_chk
    import wander_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       near,
    input logic       peer_l,
    input logic       peer_r,
    input logic       obst_l,
    input logic       obst_r,
    input logic [4:0] cmd,
    input logic       busy
);
    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cmd) == 1);

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cmd));

    a_r3_peer_left: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && tick && near && peer_l) |=> (cmd == MV_RIGHT));

    a_r10_blocked_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && tick && near && obst_l && obst_r && !peer_l && !peer_r)
        |=> (cmd == MV_STOP && busy));

    a_r6_fwd_then_turn: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd) == MV_FWD && cmd != MV_FWD) |-> (cmd == MV_LEFT || cmd == MV_RIGHT));

    a_r8_back_then_turn: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd) == MV_BACK && cmd != MV_BACK) |-> (cmd == MV_LEFT || cmd == MV_RIGHT));
endmodule

bind wander_ctrl wander_ctrl_chk u_chk (.*);

// File: tb/wander_ctrl_tb.sv
`timescale 1ns/1ps
module wander_ctrl_tb;
    localparam logic [4:0] FWD = 5'b00001, LFT = 5'b00010, RGT = 5'b00100,
                           BCK = 5'b01000, STP = 5'b10000;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic near = 0, peer_l = 0, peer_r = 0, obst_l = 0, obst_r = 0;
    logic [4:0] cmd;
    logic busy;
    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wander_ctrl #(.FWD_TICKS(3), .TURN_TICKS(2), .BACK_TICKS(2), .WAIT_TICKS(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .near(near), .peer_l(peer_l),
        .peer_r(peer_r), .obst_l(obst_l), .obst_r(obst_r), .cmd(cmd), .busy(busy));

    // {near, peer_l, peer_r, obst_l, obst_r, expected command}
    localparam logic [9:0] VEC [11] = '{
        {5'b11000, RGT},   // R3 robot left
        {5'b10100, LFT},   // R3 robot right
        {5'b11100, RGT},   // R3 both robots, left nearest
        {5'b10110, LFT},   // R5 robot right beats obstacle left
        {5'b11001, RGT},   // R5 robot left beats obstacle right
        {5'b10001, LFT},   // R4 obstacle right
        {5'b10010, RGT},   // R4 obstacle left
        {5'b10011, STP},   // R10 both sides
        {5'b00011, FWD},   // R6 not near
        {5'b10000, FWD},   // R6 near, no flag
        {5'b01000, FWD}    // R6 robot but far
    };

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic chk_turn(input string req);
        total++;
        if (cmd !== LFT && cmd !== RGT) begin
            bad++;
            $display("FAIL %s act=%b exp=turn", req, cmd);
        end
    endtask

    task automatic setin(input logic [4:0] f);
        {near, peer_l, peer_r, obst_l, obst_r} = f;
    endtask

    task automatic step();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; setin(5'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one reactive turn plus its full duration
    task automatic turn_seq(input logic [4:0] f);
        setin(f); step(); setin(5'b0); step(); step();
    endtask

    initial begin
        do_reset();
        chk("R1 reset cmd", cmd, STP);
        chk("R1 reset busy", {4'b0, busy}, 5'b0);

        for (int i = 0; i < 11; i++) begin
            do_reset();
            setin(VEC[i][9:5]);
            step();
            chk($sformatf("R3/R4/R5/R6/R10 vec%0d cmd", i), cmd, VEC[i][4:0]);
            chk($sformatf("R3/R4/R5/R6/R10 vec%0d busy", i), {4'b0, busy}, 5'b1);
        end

        // R2: no tick, no change
        do_reset();
        setin(5'b11000);
        repeat (6) @(negedge clk);
        chk("R2 idle hold", cmd, STP);
        step();
        setin(5'b00000);
        repeat (6) @(negedge clk);
        chk("R2 turn hold", cmd, RGT);

        // R7: turn length then idle
        do_reset();
        setin(5'b10001); step(); setin(5'b0);
        step();
        chk("R7 still turning", cmd, LFT);
        step();
        chk("R7 idle cmd", cmd, STP);
        chk("R7 idle busy", {4'b0, busy}, 5'b0);

        // R6 / R12: forward step then random turn
        do_reset();
        step(); step(); step();
        chk("R6 forward", cmd, FWD);
        step();
        chk_turn("R6 R12 random turn");
        step(); step();
        chk("R6 back idle", cmd, STP);

        // R8: three same-direction turns
        do_reset();
        turn_seq(5'b10001);
        turn_seq(5'b10001);
        turn_seq(5'b10001);
        chk("R8 back up", cmd, BCK);
        step();
        chk("R8 back up held", cmd, BCK);
        step();
        chk("R8 opposite turn", cmd, RGT);
        step(); step();
        chk("R8 idle after escape", cmd, STP);

        // R9: direction change restarts the run
        do_reset();
        turn_seq(5'b10001);
        turn_seq(5'b10010);
        turn_seq(5'b10001);
        turn_seq(5'b10001);
        chk("R9 no escape after change", {busy, cmd[3:0]}, {1'b0, 4'b0000});
        turn_seq(5'b10001);
        chk("R9 third in run escapes", cmd, BCK);

        // R9: forward step clears the run
        do_reset();
        turn_seq(5'b10001);
        turn_seq(5'b10001);
        step(); step(); step(); step(); step(); step();
        turn_seq(5'b10001);
        chk("R9 forward cleared run", {busy, cmd}, {1'b0, STP});

        // R10: blockage released
        do_reset();
        setin(5'b10011); step();
        setin(5'b0); step();
        chk("R10 release idle", {busy, cmd}, {1'b0, STP});

        // R11: persistent blockage
        do_reset();
        setin(5'b10011); step();
        step(); step(); step(); step();
        chk("R11 still waiting", {busy, cmd}, {1'b1, STP});
        step();
        chk("R11 back up", cmd, BCK);
        setin(5'b0);
        step(); step();
        chk_turn("R11 R12 random escape");
        step(); step();
        chk("R11 idle", cmd, STP);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule